// File: doc/BRIEF.md
# Rain-Driven Roof Controller Core

This block is a small single-cycle processor that runs a fixed integer program held in an internal ROM. Its only job is to steer a roof motor from a rain sensor. It implements a reduced slice of RV32I: addi (`li` is this with rs1 = x0), andi, slli, and, or, lw, sw, beq (used as `beqz` with rs2 = x0) and jal (used as `j` with rd = x0). General register x30 also serves as the I/O port. On every clock edge its bit 0 is overwritten with the sensor pin. Its bit 1 is copied to the motor pin through an output register.

The built-in roof program reads x30 bit 0 in a loop. A sensor value of 0 means rain: the program clears bit 1 with the mask 0xFFFFFFFD and then ORs in 1 shifted left by one, so the roof closes and x30 reads 2. A sensor value of 1 means dry: the program applies the same mask and ORs in zero, so the roof opens and x30 reads 1. The stack lives in a small word-addressed data RAM. A loaded-flag input tells the core that its instruction memory is already filled. While the flag is low, the core waits.

A parameter selects the ROM image. Image 0 is the roof program. Image 1 is a self-test program that drives its intermediate results onto the motor pin, so every supported operation can be seen at the port.

Top module: `roof_core`

## Requirements
- R1: While `rst` is high and on the first edge after it, `roof_out` is 0, the PC holds `ROM_BASE`, and x30 is zero apart from the sensor bit.
- R2: With `prog_loaded` high, the core retires one instruction per rising edge. The first instruction is taken from `ROM_BASE` on the first edge after reset is released. The PC stays word aligned and advances by 4 unless a branch or jump is taken.
- R3: While `prog_loaded` is low, no instruction executes. The PC, the registers other than x30 bit 0, the data RAM and the motor state all hold.
- R4: On every edge out of reset, x30 bit 0 takes the value of `rain_in` sampled at that edge, overriding any write-back to x30 at the same edge.
- R5: `roof_out` equals the value that x30 bit 1 held before the previous edge. This gives one register stage between the port bit and the pin.
- R6: Opcode 0x13 with funct3 0 (addi), 7 (andi) and 1 (slli, funct7 = 0) is executed, and so is opcode 0x33 with funct7 = 0 and funct3 7 (and) or 6 (or). Each writes its result to rd.
- R7: Opcode 0x03 with funct3 2 (lw) and opcode 0x23 with funct3 2 (sw) access `DMEM_WORDS` words starting at `DATA_BASE`. A store to an address outside that window, or to an unaligned address, changes nothing. A load from such an address returns 0.
- R8: Opcode 0x63 with funct3 0 jumps to PC + B-immediate when rs1 equals rs2, and falls through to PC + 4 otherwise. Opcode 0x6F jumps to PC + J-immediate and writes PC + 4 to rd.
- R9: Register x0 always reads as zero, and any write to it is discarded.
- R10: Any other opcode, or an unsupported funct3/funct7 combination, behaves as a no-op that only advances the PC by 4.
- R11: With image 0, once `rain_in` has been held at 0 for 40 cycles, `roof_out` is 1. Once `rain_in` has been held at 1 for 40 cycles, `roof_out` is 0.
- R12: `PROG_SEL` = 1 builds the self-test image. That image shows the results of R6–R10 on `roof_out` in a fixed, sensor-dependent sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rain_in | input | 1 | Rain sensor level, 0 = wet, 1 = dry; sampled into x30 bit 0 |
| prog_loaded | input | 1 | High when the instruction memory is ready; low stalls execution |
| roof_out | output | 1 | Registered motor command from x30 bit 1, 1 = close |

## Verification
Each instruction's register, memory and PC effects land on the rising edge that retires it. The sensor value reaches x30 bit 0 on the edge that samples it. A write to x30 bit 1 shows up on `roof_out` one edge later, so a closing `or` appears on the pin two edges after it is fetched. The bench changes inputs only on falling edges. It advances an instruction-level reference model once per rising edge, using the same inputs the core sees, and compares `roof_out` for both ROM images at the next falling edge. The program-level checks for R11 wait a fixed 40 cycles, which is longer than the worst case: one pass through the polling loop plus the two-edge output delay.

// File: rtl/roof_core_pkg.sv
package roof_core_pkg;

  localparam int RC_XLEN = 32;

  localparam logic [6:0] OPC_IMM    = 7'h13;
  localparam logic [6:0] OPC_REG    = 7'h33;
  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_JAL    = 7'h6F;

  localparam logic [RC_XLEN-1:0] RC_NOP = 32'h0000_0013;

  typedef enum logic [3:0] {
    K_NOP, K_ADDI, K_ANDI, K_SLLI, K_AND, K_OR, K_LW, K_SW, K_BEQ, K_JAL
  } rc_kind_e;

  typedef struct packed {
    rc_kind_e             kind;
    logic [4:0]           rd;
    logic [4:0]           rs1;
    logic [4:0]           rs2;
    logic [RC_XLEN-1:0]   imm;
  } rc_dec_t;

  // ---- instruction builders used to compute the ROM images ----
  function automatic logic [31:0] a_itype(input int imm, input int rs1,
                                          input logic [2:0] f3, input int rd,
                                          input logic [6:0] opc);
    logic [31:0] iv, s1, d;
    iv = imm; s1 = rs1; d = rd;
    return {iv[11:0], s1[4:0], f3, d[4:0], opc};
  endfunction

  function automatic logic [31:0] a_addi(input int rd, input int rs1, input int imm);
    return a_itype(imm, rs1, 3'd0, rd, OPC_IMM);
  endfunction

  function automatic logic [31:0] a_andi(input int rd, input int rs1, input int imm);
    return a_itype(imm, rs1, 3'd7, rd, OPC_IMM);
  endfunction

  function automatic logic [31:0] a_slli(input int rd, input int rs1, input int sh);
    return a_itype(sh & 31, rs1, 3'd1, rd, OPC_IMM);
  endfunction

  function automatic logic [31:0] a_lw(input int rd, input int rs1, input int off);
    return a_itype(off, rs1, 3'd2, rd, OPC_LOAD);
  endfunction

  function automatic logic [31:0] a_rtype(input int rd, input int rs1, input int rs2,
                                          input logic [2:0] f3);
    logic [31:0] d, s1, s2;
    d = rd; s1 = rs1; s2 = rs2;
    return {7'd0, s2[4:0], s1[4:0], f3, d[4:0], OPC_REG};
  endfunction

  function automatic logic [31:0] a_and(input int rd, input int rs1, input int rs2);
    return a_rtype(rd, rs1, rs2, 3'd7);
  endfunction

  function automatic logic [31:0] a_or(input int rd, input int rs1, input int rs2);
    return a_rtype(rd, rs1, rs2, 3'd6);
  endfunction

  function automatic logic [31:0] a_sw(input int rs2, input int rs1, input int off);
    logic [31:0] o, s1, s2;
    o = off; s1 = rs1; s2 = rs2;
    return {o[11:5], s2[4:0], s1[4:0], 3'd2, o[4:0], OPC_STORE};
  endfunction

  function automatic logic [31:0] a_beq(input int rs1, input int rs2, input int off);
    logic [31:0] o, s1, s2;
    o = off; s1 = rs1; s2 = rs2;
    return {o[12], o[10:5], s2[4:0], s1[4:0], 3'd0, o[4:1], o[11], OPC_BRANCH};
  endfunction

  function automatic logic [31:0] a_jal(input int rd, input int off);
    logic [31:0] o, d;
    o = off; d = rd;
    return {o[20], o[10:1], o[11], o[19:12], d[4:0], OPC_JAL};
  endfunction

  // ---- ROM images: 0 = roof control loop, 1 = self-test ----
  function automatic logic [31:0] rc_prog_word(input int sel, input int idx);
    logic [31:0] w;
    w = RC_NOP;
    if (sel == 0) begin
      case (idx)
        0:  w = a_addi(2, 0, 'h110);
        1:  w = a_slli(2, 2, 4);
        2:  w = a_addi(2, 2, -32);
        3:  w = a_addi(8, 2, 32);
        4:  w = a_sw(0, 8, -20);
        5:  w = a_addi(15, 0, -3);
        6:  w = a_sw(15, 8, -24);
        7:  w = a_lw(15, 8, -20);
        8:  w = a_slli(15, 15, 1);
        9:  w = a_sw(15, 8, -28);
        10: w = a_lw(15, 8, -28);
        11: w = a_lw(14, 8, -24);
        12: w = a_and(30, 30, 14);
        13: w = a_or(30, 30, 15);
        14: w = a_andi(15, 30, 1);
        15: w = a_sw(15, 8, -32);
        16: w = a_lw(15, 8, -32);
        17: w = a_beq(15, 0, 24);
        18: w = a_sw(0, 8, -20);
        19: w = a_lw(14, 8, -24);
        20: w = a_and(30, 30, 14);
        21: w = a_or(30, 30, 0);
        22: w = a_jal(0, -32);
        23: w = a_addi(15, 0, 1);
        24: w = a_slli(15, 15, 1);
        25: w = a_lw(14, 8, -24);
        26: w = a_and(30, 30, 14);
        27: w = a_or(30, 30, 15);
        28: w = a_jal(0, -56);
        default: w = RC_NOP;
      endcase
    end else begin
      case (idx)
        0:  w = a_addi(0, 0, 7);
        1:  w = a_addi(13, 0, -3);
        2:  w = a_slli(5, 0, 1);
        3:  w = a_or(30, 30, 5);
        4:  w = a_addi(6, 0, 2);
        5:  w = a_addi(9, 0, 'h100);
        6:  w = a_slli(9, 9, 4);
        7:  w = a_sw(6, 9, 0);
        8:  w = a_addi(10, 9, 'h100);
        9:  w = a_sw(0, 10, 0);
        10: w = a_lw(11, 9, 0);
        11: w = a_or(30, 30, 11);
        12: w = 32'h0010_0073;
        13: w = a_and(30, 30, 13);
        14: w = a_lw(12, 10, 0);
        15: w = a_or(30, 30, 12);
        16: w = a_andi(7, 30, 1);
        17: w = a_slli(7, 7, 1);
        18: w = a_or(30, 30, 7);
        19: w = a_and(30, 30, 13);
        20: w = a_beq(7, 0, 12);
        21: w = a_addi(14, 0, 2);
        22: w = a_or(30, 30, 14);
        23: w = a_jal(0, -28);
        default: w = RC_NOP;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/rc_fetch.sv
module rc_fetch
  import roof_core_pkg::*;
#(
  parameter int               XLEN      = RC_XLEN,
  parameter int               ROM_WORDS = 32,
  parameter logic [XLEN-1:0]  ROM_BASE  = 32'h0001_0000,
  parameter int               PROG_SEL  = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] instr
);
  localparam int IDX_W = $clog2(ROM_WORDS);

  logic [XLEN-1:0] rom [ROM_WORDS];
  logic [XLEN-1:0] offset;
  logic            in_rom;

  for (genvar g = 0; g < ROM_WORDS; g++) begin : g_rom
    assign rom[g] = rc_prog_word(PROG_SEL, g);
  end

  always_ff @(posedge clk) begin
    if (rst)       pc <= ROM_BASE;
    else if (step) pc <= next_pc;
  end

  always_comb begin
    offset = pc - ROM_BASE;
    in_rom = ((offset >> (IDX_W + 2)) == '0) && (offset[1:0] == 2'b00);
    instr  = in_rom ? rom[offset[IDX_W+1:2]] : RC_NOP;
  end
endmodule

// File: rtl/rc_decode.sv
module rc_decode
  import roof_core_pkg::*;
#(
  parameter int XLEN = RC_XLEN
) (
  input  logic [XLEN-1:0] instr,
  output rc_dec_t         dec
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  always_comb begin
    opc = instr[6:0];
    f3  = instr[14:12];
    f7  = instr[31:25];
    dec      = '0;
    dec.kind = K_NOP;
    dec.rd   = instr[11:7];
    dec.rs1  = instr[19:15];
    dec.rs2  = instr[24:20];
    dec.imm  = {{20{instr[31]}}, instr[31:20]};
    case (opc)
      OPC_IMM: begin
        if (f3 == 3'd0)                    dec.kind = K_ADDI;
        else if (f3 == 3'd7)               dec.kind = K_ANDI;
        else if (f3 == 3'd1 && f7 == 7'd0) dec.kind = K_SLLI;
      end
      OPC_REG: begin
        if (f7 == 7'd0 && f3 == 3'd7)      dec.kind = K_AND;
        else if (f7 == 7'd0 && f3 == 3'd6) dec.kind = K_OR;
      end
      OPC_LOAD: begin
        if (f3 == 3'd2) dec.kind = K_LW;
      end
      OPC_STORE: begin
        dec.imm = {{20{instr[31]}}, instr[31:25], instr[11:7]};
        if (f3 == 3'd2) dec.kind = K_SW;
      end
      OPC_BRANCH: begin
        dec.imm = {{19{instr[31]}}, instr[31], instr[7], instr[30:25],
                   instr[11:8], 1'b0};
        if (f3 == 3'd0) dec.kind = K_BEQ;
      end
      OPC_JAL: begin
        dec.imm  = {{11{instr[31]}}, instr[31], instr[19:12], instr[20],
                    instr[30:21], 1'b0};
        dec.kind = K_JAL;
      end
      default: dec.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/rc_regfile.sv
module rc_regfile #(
  parameter int XLEN   = 32,
  parameter int NREGS  = 32,
  parameter int IO_REG = 30,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic            sense,
  output logic [1:0]      io_bits
);
  logic [XLEN-1:0] word [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign word[g] = '0;
    end else if (g == IO_REG) begin : g_io
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                               q <= '0;
        else if (we && wa == AW'(g))           q <= {wd[XLEN-1:1], sense};
        else                                   q <= {q[XLEN-1:1], sense};
      end
      assign word[g] = q;
    end else begin : g_gp
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                      q <= '0;
        else if (we && wa == AW'(g))  q <= wd;
      end
      assign word[g] = q;
    end
  end

  assign rd1     = word[ra1];
  assign rd2     = word[ra2];
  assign io_bits = word[IO_REG][1:0];
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import roof_core_pkg::*;
#(
  parameter int XLEN = RC_XLEN
) (
  input  rc_dec_t         dec,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] result,
  output logic [XLEN-1:0] mem_addr,
  output logic            wb_en,
  output logic            is_load,
  output logic            is_store,
  output logic [XLEN-1:0] next_pc
);
  logic [XLEN-1:0] seq_pc;

  always_comb begin
    seq_pc   = pc + XLEN'(4);
    result   = '0;
    wb_en    = 1'b0;
    is_load  = 1'b0;
    is_store = 1'b0;
    next_pc  = seq_pc;
    mem_addr = a + dec.imm;
    case (dec.kind)
      K_ADDI: begin result = a + dec.imm;       wb_en = 1'b1; end
      K_ANDI: begin result = a & dec.imm;       wb_en = 1'b1; end
      K_SLLI: begin result = a << dec.imm[4:0]; wb_en = 1'b1; end
      K_AND:  begin result = a & b;             wb_en = 1'b1; end
      K_OR:   begin result = a | b;             wb_en = 1'b1; end
      K_LW:   begin is_load = 1'b1;             wb_en = 1'b1; end
      K_SW:   is_store = 1'b1;
      K_BEQ:  if (a == b) next_pc = pc + dec.imm;
      K_JAL:  begin
        result  = seq_pc;
        wb_en   = 1'b1;
        next_pc = pc + dec.imm;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rc_dmem.sv
module rc_dmem #(
  parameter int               XLEN  = 32,
  parameter int               WORDS = 64,
  parameter logic [XLEN-1:0]  BASE  = 32'h0000_1000,
  localparam int              AW    = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] mem [WORDS];
  logic [XLEN-1:0] offset;
  logic            hit;
  logic [AW-1:0]   idx;

  always_comb begin
    offset = addr - BASE;
    hit    = ((offset >> (AW + 2)) == '0) && (offset[1:0] == 2'b00);
    idx    = offset[AW+1:2];
  end

  always_ff @(posedge clk) begin
    if (we && hit) mem[idx] <= wdata;
  end

  assign rdata = hit ? mem[idx] : '0;
endmodule

// File: rtl/roof_core.sv
module roof_core
  import roof_core_pkg::*;
#(
  parameter int               XLEN       = RC_XLEN,
  parameter int               ROM_WORDS  = 32,
  parameter int               DMEM_WORDS = 64,
  parameter int               NREGS      = 32,
  parameter int               IO_REG     = 30,
  parameter logic [XLEN-1:0]  ROM_BASE   = 32'h0001_0000,
  parameter logic [XLEN-1:0]  DATA_BASE  = 32'h0000_1000,
  parameter int               PROG_SEL   = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic rain_in,
  input  logic prog_loaded,
  output logic roof_out
);
  localparam int RAW = $clog2(NREGS);

  logic [XLEN-1:0] pc, instr, next_pc;
  logic [XLEN-1:0] rs1_val, rs2_val, alu_res, mem_addr, ld_data, wb_data;
  logic            wb_en, is_load, is_store;
  logic [1:0]      io_bits;
  rc_dec_t         dec;

  rc_fetch #(
    .XLEN(XLEN), .ROM_WORDS(ROM_WORDS), .ROM_BASE(ROM_BASE), .PROG_SEL(PROG_SEL)
  ) u_fetch (
    .clk(clk), .rst(rst), .step(prog_loaded), .next_pc(next_pc),
    .pc(pc), .instr(instr)
  );

  rc_decode #(.XLEN(XLEN)) u_dec (.instr(instr), .dec(dec));

  rc_regfile #(.XLEN(XLEN), .NREGS(NREGS), .IO_REG(IO_REG)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(dec.rs1[RAW-1:0]), .ra2(dec.rs2[RAW-1:0]),
    .rd1(rs1_val), .rd2(rs2_val),
    .we(wb_en && prog_loaded), .wa(dec.rd[RAW-1:0]), .wd(wb_data),
    .sense(rain_in), .io_bits(io_bits)
  );

  rc_alu #(.XLEN(XLEN)) u_alu (
    .dec(dec), .pc(pc), .a(rs1_val), .b(rs2_val),
    .result(alu_res), .mem_addr(mem_addr), .wb_en(wb_en),
    .is_load(is_load), .is_store(is_store), .next_pc(next_pc)
  );

  rc_dmem #(.XLEN(XLEN), .WORDS(DMEM_WORDS), .BASE(DATA_BASE)) u_dmem (
    .clk(clk), .we(is_store && prog_loaded), .addr(mem_addr),
    .wdata(rs2_val), .rdata(ld_data)
  );

  assign wb_data = is_load ? ld_data : alu_res;

  always_ff @(posedge clk) begin
    if (rst) roof_out <= 1'b0;
    else     roof_out <= io_bits[1];
  end
endmodule

// File: rtl/roof_core_chk.sv
module roof_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            rain_in,
  input logic            prog_loaded,
  input logic            roof_out,
  input logic [XLEN-1:0] pc,
  input logic [1:0]      io_bits
);
  p_pc_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  p_stall_holds_pc_r3: assert property (@(posedge clk) disable iff (rst)
    !prog_loaded |=> $stable(pc));

  p_sensor_into_port_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> io_bits[0] == $past(rain_in));

  p_motor_follows_port_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> roof_out == $past(io_bits[1]));
endmodule

bind roof_core roof_core_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .rain_in(rain_in), .prog_loaded(prog_loaded),
  .roof_out(roof_out), .pc(pc), .io_bits(io_bits)
);

// File: tb/sim_roof_core.sv
module sim_roof_core;
  import roof_core_pkg::*;

  localparam logic [31:0] ROM_BASE  = 32'h0001_0000;
  localparam logic [31:0] DATA_BASE = 32'h0000_1000;
  localparam int          ROM_WORDS = 32;
  localparam int          DM_WORDS  = 64;

  logic clk = 1'b0, rst = 1'b1, rain = 1'b1, loaded = 1'b0;
  logic roof0, roof1;
  int   n_checks = 0, n_errors = 0;
  bit   finished = 1'b0;

  roof_core #(.PROG_SEL(0)) u0 (.clk(clk), .rst(rst), .rain_in(rain),
                                .prog_loaded(loaded), .roof_out(roof0));
  roof_core #(.PROG_SEL(1)) u1 (.clk(clk), .rst(rst), .rain_in(rain),
                                .prog_loaded(loaded), .roof_out(roof1));

  always #4 clk = ~clk;

  // ---- instruction-level reference model, one per image ----
  logic [31:0] m_reg [2][32];
  logic [31:0] m_mem [2][DM_WORDS];
  logic [31:0] m_pc  [2];
  logic        m_roof[2];

  function automatic bit in_dmem(input logic [31:0] addr);
    logic [31:0] off;
    off = addr - DATA_BASE;
    return (off < DM_WORDS * 4) && (off[1:0] == 0);
  endfunction

  task automatic exec_one(input int k);
    logic [31:0] w, a, b, ia, sa, ba, ja, npc, off;
    int rd;
    off = m_pc[k] - ROM_BASE;
    w   = (off < ROM_WORDS * 4 && off[1:0] == 0) ? rc_prog_word(k, int'(off >> 2))
                                                 : 32'h13;
    rd  = int'(w[11:7]);
    a   = m_reg[k][w[19:15]];
    b   = m_reg[k][w[24:20]];
    ia  = 32'(signed'(w[31:20]));
    sa  = 32'(signed'({w[31:25], w[11:7]}));
    ba  = 32'(signed'({w[31], w[7], w[30:25], w[11:8], 1'b0}));
    ja  = 32'(signed'({w[31], w[19:12], w[20], w[30:21], 1'b0}));
    npc = m_pc[k] + 4;
    case (w[6:0])
      7'h13: begin
        if (w[14:12] == 0)                        m_reg[k][rd] = a + ia;
        else if (w[14:12] == 7)                   m_reg[k][rd] = a & ia;
        else if (w[14:12] == 1 && w[31:25] == 0)  m_reg[k][rd] = a << w[24:20];
      end
      7'h33: if (w[31:25] == 0) begin
        if (w[14:12] == 7)      m_reg[k][rd] = a & b;
        else if (w[14:12] == 6) m_reg[k][rd] = a | b;
      end
      7'h03: if (w[14:12] == 2)
        m_reg[k][rd] = in_dmem(a + ia) ? m_mem[k][((a + ia - DATA_BASE) >> 2)] : 32'h0;
      7'h23: if (w[14:12] == 2 && in_dmem(a + sa))
        m_mem[k][((a + sa - DATA_BASE) >> 2)] = b;
      7'h63: if (w[14:12] == 0 && a == b) npc = m_pc[k] + ba;
      7'h6F: begin m_reg[k][rd] = m_pc[k] + 4; npc = m_pc[k] + ja; end
      default: ;
    endcase
    m_pc[k] = npc;
  endtask

  task automatic model_step(input int k);
    if (rst) begin
      for (int i = 0; i < 32; i++) m_reg[k][i] = 0;
      m_pc[k]   = ROM_BASE;
      m_roof[k] = 1'b0;
    end else begin
      m_roof[k] = m_reg[k][30][1];
      if (loaded) exec_one(k);
      m_reg[k][30][0] = rain;
      m_reg[k][0]     = 0;
    end
  endtask

  always @(posedge clk) begin
    model_step(0);
    model_step(1);
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check("R2/R4/R5/R11 roof image", roof0, m_roof[0]);
      check("R6/R7/R8/R9/R10/R12 self-test image", roof1, m_roof[1]);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic held;
    cycles(3);
    check("R1 reset roof0", roof0, 1'b0);
    check("R1 reset roof1", roof1, 1'b0);
    rst  = 1'b0;
    rain = 1'b0;
    cycles(20);
    check("R3 unloaded core stays open", roof0, 1'b0);
    loaded = 1'b1;
    cycles(40);
    check("R11 wet closes roof", roof0, 1'b1);
    rain = 1'b1;
    cycles(40);
    check("R11 dry opens roof", roof0, 1'b0);
    for (int p = 1; p < 9; p++) begin
      for (int r = 0; r < 6; r++) begin
        rain = ~rain;
        cycles(p);
      end
    end
    rain = 1'b0;
    cycles(40);
    check("R11 wet after toggling", roof0, 1'b1);
    loaded = 1'b0;
    cycles(2);
    held = roof0;
    for (int i = 0; i < 20; i++) begin
      rain = i[0];
      cycles(1);
    end
    check("R3 stalled motor holds", roof0, held);
    loaded = 1'b1;
    rain   = 1'b1;
    cycles(40);
    check("R11 dry after stall", roof0, 1'b0);
    rst = 1'b1;
    cycles(2);
    check("R1 mid-run reset roof0", roof0, 1'b0);
    check("R1 mid-run reset roof1", roof1, 1'b0);
    rst  = 1'b0;
    rain = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (i % 13 == 0) rain = ~rain;
      cycles(1);
    end
    finish_run();
  end
endmodule